// File: doc/BRIEF.md
# Per-Thread Commit Squash Controller

This block keeps, for every hardware thread of an out-of-order core, the squash bookkeeping of the commit stage. Three kinds of squash reach it. A fault or interrupt arms a per-thread countdown whose length is programmable, and it squashes the whole thread only when that countdown runs out. A thread-context request also squashes the whole thread. The execute stage can ask for a partial squash back to a given sequence number. For each thread the block records the youngest sequence number accepted into the reorder buffer. It rejects an execute squash that points past that record, so a squash from a younger instruction cannot replace one from an older instruction. When a trap squash and a context squash are pending in the same cycle, the trap squash is handled first.

For each thread the block drives a broadcast toward the earlier pipeline stages. The broadcast carries a one-cycle squash pulse, the squash point sequence number, a squash-in-progress flag, a mispredict flag and a redirect PC. The thread then stays in its squashing state until the reorder buffer reports that the squash has finished. The reorder buffer, fetch and rename are outside the block. They appear only as an insert strobe, head and empty status, and a squash-done strobe for each thread. All vector ports are flat, and thread t occupies slice t of each one.

Top module: `cmt_squash_ctrl`

## Requirements
- R1: A trap request (thread state code 3) or a fetch-trap request (state code 4) is accepted only in Idle (0) or Running (1). It loads the countdown with `trap_lat` = L. The whole-thread squash pulse appears on the outputs L+2 clock edges after the edge that accepted the request, and not earlier.
- R2: If the trap flag and the context flag are pending together, `conflict` is high. The trap squash is handled first and the context squash on the following cycle, so `bc_squash` is high for two cycles in a row.
- R3: An execute squash is accepted only when the thread is not in state 3 and `ex_seq` is less than or equal to the thread's youngest sequence number. Otherwise it has no effect on the outputs. A fetch-trap (state 4) does not block it.
- R4: An accepted execute squash broadcasts the squash point `ex_seq` − `ex_incl`. It copies `ex_mispred` and `ex_pc`, and the youngest record becomes the squash point.
- R5: A whole-thread squash broadcasts the squash point `rob_head_seq` − 1, or 0 when `rob_empty` is set. It clears the mispredict flag, redirects to `saved_pc` and resets the youngest record to 0.
- R6: In the squashing state (code 2), a cycle with `rob_sq_done` returns the thread to Running (1). A cycle without it reasserts `bc_busy`.
- R7: An insert sets the youngest record to `ins_seq` and moves Idle to Running. An insert made while the thread is squashing is ignored.
- R8: After reset every thread is Idle, all broadcast outputs are 0, no squash is pending and no countdown runs.
- R9: `bc_squash` is a single-cycle pulse for each handled squash, and threads do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_lat | input | LAT_W | Countdown length for trap squashes |
| trap_req | input | NT | Fault/interrupt trap request per thread |
| ftrap_req | input | NT | Fetch-side trap request per thread |
| ctx_req | input | NT | Thread-context squash request per thread |
| ex_valid | input | NT | Execute-stage squash request |
| ex_seq | input | NT*SEQ_W | Sequence number of the squashing instruction |
| ex_incl | input | NT | Include the squashing instruction in the squash |
| ex_mispred | input | NT | Squash is a branch mispredict |
| ex_pc | input | NT*PC_W | Redirect PC from execute |
| ins_valid | input | NT | Instruction accepted into the reorder buffer |
| ins_seq | input | NT*SEQ_W | Sequence number of the inserted instruction |
| rob_empty | input | NT | Reorder buffer holds nothing for the thread |
| rob_head_seq | input | NT*SEQ_W | Sequence number at the reorder buffer head |
| rob_sq_done | input | NT | Reorder buffer finished squashing |
| saved_pc | input | NT*PC_W | Thread's committed PC for whole-thread redirect |
| thr_state | output | NT*3 | Thread state code |
| bc_squash | output | NT | Squash pulse |
| bc_busy | output | NT | Squash in progress |
| bc_mispred | output | NT | Mispredict flag of the broadcast |
| bc_done_seq | output | NT*SEQ_W | Broadcast squash point |
| bc_redirect | output | NT*PC_W | Broadcast redirect PC |
| conflict | output | NT | Trap and context squash pending together |

## Verification
The hardest case to reach is the collision of a trap squash and a context squash in the same cycle. The trap flag appears only when the countdown expires, so a port request cannot set it directly. The bench uses a zero-length countdown and issues the context request on exactly the edge where that countdown expires, so both flags become pending together. The other sweeps cover every countdown length for both trap kinds on both threads. They also walk the execute squash sequence number across the youngest boundary, with and without the include flag.

// File: rtl/cmt_sq_pkg.sv
package cmt_sq_pkg;
   typedef enum logic [2:0] {
      THR_IDLE   = 3'd0,
      THR_RUN    = 3'd1,
      THR_SQUASH = 3'd2,
      THR_TRAP   = 3'd3,
      THR_FTRAP  = 3'd4
   } thr_state_e;

   localparam int unsigned STATE_W = 3;
endpackage

// File: rtl/cmt_trap_timer.sv
module cmt_trap_timer #(
   parameter int unsigned LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LAT_W-1:0] lat,
   output logic             running,
   output logic             fire
);
   if (LAT_W < 1) begin : g_bad_lat
      $error("cmt_trap_timer: LAT_W must be at least 1");
   end

   logic [LAT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         cnt_q <= lat;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign running = run_q;
   assign fire    = run_q && (cnt_q == '0);

   a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !start && cnt_q != '0) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cmt_seq_filter.sv
module cmt_seq_filter #(
   parameter int unsigned SEQ_W = 8
) (
   input  logic             valid,
   input  logic             blocked,
   input  logic [SEQ_W-1:0] seq,
   input  logic             incl,
   input  logic [SEQ_W-1:0] youngest,
   output logic             accept,
   output logic [SEQ_W-1:0] point
);
   if (SEQ_W < 2) begin : g_bad_seq
      $error("cmt_seq_filter: SEQ_W must be at least 2");
   end

   assign accept = valid && !blocked && (seq <= youngest);
   assign point  = incl ? seq - 1'b1 : seq;
endmodule

// File: rtl/cmt_thread_sq.sv
module cmt_thread_sq
   import cmt_sq_pkg::*;
#(
   parameter int unsigned SEQ_W = 8,
   parameter int unsigned PC_W  = 16,
   parameter int unsigned LAT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LAT_W-1:0]   trap_lat,
   input  logic               trap_req,
   input  logic               ftrap_req,
   input  logic               ctx_req,
   input  logic               ex_valid,
   input  logic [SEQ_W-1:0]   ex_seq,
   input  logic               ex_incl,
   input  logic               ex_mispred,
   input  logic [PC_W-1:0]    ex_pc,
   input  logic               ins_valid,
   input  logic [SEQ_W-1:0]   ins_seq,
   input  logic               rob_empty,
   input  logic [SEQ_W-1:0]   rob_head_seq,
   input  logic               rob_sq_done,
   input  logic [PC_W-1:0]    saved_pc,
   output logic [STATE_W-1:0] state_o,
   output logic               bc_squash,
   output logic               bc_busy,
   output logic               bc_mispred,
   output logic [SEQ_W-1:0]   bc_done_seq,
   output logic [PC_W-1:0]    bc_redirect,
   output logic               conflict
);
   thr_state_e       st_q, st_a, st_n;
   logic [SEQ_W-1:0] yng_q, yng_a, yng_n;
   logic             tflag_q, cflag_q;
   logic             sq_q, busy_q, mp_q;
   logic [SEQ_W-1:0] done_q, done_a, done_n;
   logic [PC_W-1:0]  rd_q, rd_a, rd_n;
   logic             sq_a, busy_a, mp_a, sq_n, busy_n, mp_n;
   logic             tmr_start, tmr_run, tmr_fire;
   logic             ex_acc;
   logic [SEQ_W-1:0] ex_point;
   logic             take_trap, take_ctx;

   assign take_trap = tflag_q;
   assign take_ctx  = cflag_q && !tflag_q;

   // Stage A: squash-in-progress tracking and whole-thread squashes
   always_comb begin
      st_a   = st_q;
      yng_a  = yng_q;
      sq_a   = 1'b0;
      busy_a = 1'b0;
      mp_a   = 1'b0;
      done_a = done_q;
      rd_a   = rd_q;
      if (st_q == THR_SQUASH) begin
         if (rob_sq_done) st_a = THR_RUN;
         else             busy_a = 1'b1;
      end
      if (take_trap || take_ctx) begin
         done_a = rob_empty ? '0 : rob_head_seq - 1'b1;
         yng_a  = '0;
         sq_a   = 1'b1;
         busy_a = 1'b1;
         mp_a   = 1'b0;
         rd_a   = saved_pc;
         st_a   = THR_SQUASH;
      end
   end

   cmt_seq_filter #(.SEQ_W(SEQ_W)) u_filter (
      .valid    (ex_valid),
      .blocked  (st_a == THR_TRAP),
      .seq      (ex_seq),
      .incl     (ex_incl),
      .youngest (yng_a),
      .accept   (ex_acc),
      .point    (ex_point)
   );

   // Stage B: execute squash, insertion, trap arming
   always_comb begin
      st_n      = st_a;
      yng_n     = yng_a;
      sq_n      = sq_a;
      busy_n    = busy_a;
      mp_n      = mp_a;
      done_n    = done_a;
      rd_n      = rd_a;
      tmr_start = 1'b0;
      if (ex_acc) begin
         done_n = ex_point;
         yng_n  = ex_point;
         sq_n   = 1'b1;
         busy_n = 1'b1;
         mp_n   = ex_mispred;
         rd_n   = ex_pc;
         st_n   = THR_SQUASH;
      end
      if (ins_valid && st_n != THR_SQUASH) begin
         yng_n = ins_seq;
         if (st_n == THR_IDLE) st_n = THR_RUN;
      end
      if ((trap_req || ftrap_req) && (st_n == THR_IDLE || st_n == THR_RUN)) begin
         tmr_start = 1'b1;
         st_n      = trap_req ? THR_TRAP : THR_FTRAP;
      end
   end

   cmt_trap_timer #(.LAT_W(LAT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .lat     (trap_lat),
      .running (tmr_run),
      .fire    (tmr_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= THR_IDLE;
         yng_q   <= '0;
         tflag_q <= 1'b0;
         cflag_q <= 1'b0;
         sq_q    <= 1'b0;
         busy_q  <= 1'b0;
         mp_q    <= 1'b0;
         done_q  <= '0;
         rd_q    <= '0;
      end else begin
         st_q    <= st_n;
         yng_q   <= yng_n;
         tflag_q <= (tflag_q && !take_trap) || (tmr_fire && !tmr_start);
         cflag_q <= (cflag_q && !take_ctx) || ctx_req;
         sq_q    <= sq_n;
         busy_q  <= busy_n;
         mp_q    <= mp_n;
         done_q  <= done_n;
         rd_q    <= rd_n;
      end
   end

   assign state_o     = st_q;
   assign bc_squash   = sq_q;
   assign bc_busy     = busy_q;
   assign bc_mispred  = mp_q;
   assign bc_done_seq = done_q;
   assign bc_redirect = rd_q;
   assign conflict    = tflag_q && cflag_q;

   a_r1_flag_from_timer: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tflag_q) |-> $past(tmr_run));
   a_r2_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
      (tflag_q && cflag_q) |=> (bc_squash && cflag_q && !tflag_q));
   a_r3_stale_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_seq > yng_q && !tflag_q && !cflag_q) |=> !bc_squash);
   a_r3_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == THR_TRAP && !tflag_q && !cflag_q) |=> !bc_squash);
   a_r5_full_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      ((tflag_q || cflag_q) && !(ex_valid && ex_seq == '0))
         |=> (bc_squash && !bc_mispred && bc_redirect == $past(saved_pc)));
   a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == THR_SQUASH && !rob_sq_done) |=> bc_busy);
endmodule

// File: rtl/cmt_squash_ctrl.sv
module cmt_squash_ctrl
   import cmt_sq_pkg::*;
#(
   parameter int unsigned NT    = 2,
   parameter int unsigned SEQ_W = 8,
   parameter int unsigned PC_W  = 16,
   parameter int unsigned LAT_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LAT_W-1:0]      trap_lat,
   input  logic [NT-1:0]         trap_req,
   input  logic [NT-1:0]         ftrap_req,
   input  logic [NT-1:0]         ctx_req,
   input  logic [NT-1:0]         ex_valid,
   input  logic [NT*SEQ_W-1:0]   ex_seq,
   input  logic [NT-1:0]         ex_incl,
   input  logic [NT-1:0]         ex_mispred,
   input  logic [NT*PC_W-1:0]    ex_pc,
   input  logic [NT-1:0]         ins_valid,
   input  logic [NT*SEQ_W-1:0]   ins_seq,
   input  logic [NT-1:0]         rob_empty,
   input  logic [NT*SEQ_W-1:0]   rob_head_seq,
   input  logic [NT-1:0]         rob_sq_done,
   input  logic [NT*PC_W-1:0]    saved_pc,
   output logic [NT*STATE_W-1:0] thr_state,
   output logic [NT-1:0]         bc_squash,
   output logic [NT-1:0]         bc_busy,
   output logic [NT-1:0]         bc_mispred,
   output logic [NT*SEQ_W-1:0]   bc_done_seq,
   output logic [NT*PC_W-1:0]    bc_redirect,
   output logic [NT-1:0]         conflict
);
   if (NT < 1) begin : g_bad_nt
      $error("cmt_squash_ctrl: NT must be at least 1");
   end
   if (PC_W < 1) begin : g_bad_pc
      $error("cmt_squash_ctrl: PC_W must be at least 1");
   end

   for (genvar t = 0; t < NT; t++) begin : g_thr
      cmt_thread_sq #(.SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) u_thr (
         .clk          (clk),
         .rst_n        (rst_n),
         .trap_lat     (trap_lat),
         .trap_req     (trap_req[t]),
         .ftrap_req    (ftrap_req[t]),
         .ctx_req      (ctx_req[t]),
         .ex_valid     (ex_valid[t]),
         .ex_seq       (ex_seq[t*SEQ_W +: SEQ_W]),
         .ex_incl      (ex_incl[t]),
         .ex_mispred   (ex_mispred[t]),
         .ex_pc        (ex_pc[t*PC_W +: PC_W]),
         .ins_valid    (ins_valid[t]),
         .ins_seq      (ins_seq[t*SEQ_W +: SEQ_W]),
         .rob_empty    (rob_empty[t]),
         .rob_head_seq (rob_head_seq[t*SEQ_W +: SEQ_W]),
         .rob_sq_done  (rob_sq_done[t]),
         .saved_pc     (saved_pc[t*PC_W +: PC_W]),
         .state_o      (thr_state[t*STATE_W +: STATE_W]),
         .bc_squash    (bc_squash[t]),
         .bc_busy      (bc_busy[t]),
         .bc_mispred   (bc_mispred[t]),
         .bc_done_seq  (bc_done_seq[t*SEQ_W +: SEQ_W]),
         .bc_redirect  (bc_redirect[t*PC_W +: PC_W]),
         .conflict     (conflict[t])
      );
   end
endmodule

// File: tb/cmt_squash_ctrl_test.sv
`timescale 1ns/1ps
module cmt_squash_ctrl_test;
   localparam int NT = 2, SEQ_W = 8, PC_W = 16, LAT_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LAT_W-1:0]    trap_lat = '0;
   logic [NT-1:0]       trap_req = '0, ftrap_req = '0, ctx_req = '0;
   logic [NT-1:0]       ex_valid = '0, ex_incl = '0, ex_mispred = '0;
   logic [NT*SEQ_W-1:0] ex_seq = '0, ins_seq = '0, rob_head_seq = '0;
   logic [NT*PC_W-1:0]  ex_pc = '0, saved_pc = '0;
   logic [NT-1:0]       ins_valid = '0, rob_empty = '1, rob_sq_done = '0;
   logic [NT*3-1:0]     thr_state;
   logic [NT-1:0]       bc_squash, bc_busy, bc_mispred, conflict;
   logic [NT*SEQ_W-1:0] bc_done_seq;
   logic [NT*PC_W-1:0]  bc_redirect;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   cmt_squash_ctrl #(.NT(NT), .SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) uut (
      .clk(clk), .rst_n(rst_n), .trap_lat(trap_lat), .trap_req(trap_req),
      .ftrap_req(ftrap_req), .ctx_req(ctx_req), .ex_valid(ex_valid),
      .ex_seq(ex_seq), .ex_incl(ex_incl), .ex_mispred(ex_mispred), .ex_pc(ex_pc),
      .ins_valid(ins_valid), .ins_seq(ins_seq), .rob_empty(rob_empty),
      .rob_head_seq(rob_head_seq), .rob_sq_done(rob_sq_done), .saved_pc(saved_pc),
      .thr_state(thr_state), .bc_squash(bc_squash), .bc_busy(bc_busy),
      .bc_mispred(bc_mispred), .bc_done_seq(bc_done_seq),
      .bc_redirect(bc_redirect), .conflict(conflict)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      trap_req = '0; ftrap_req = '0; ctx_req = '0;
      ex_valid = '0; ins_valid = '0; rob_sq_done = '0;
   endtask

   function automatic logic [2:0] st(input int t);
      return thr_state[t*3 +: 3];
   endfunction
   function automatic logic [SEQ_W-1:0] dseq(input int t);
      return bc_done_seq[t*SEQ_W +: SEQ_W];
   endfunction
   function automatic logic [PC_W-1:0] rdir(input int t);
      return bc_redirect[t*PC_W +: PC_W];
   endfunction

   task automatic insert(input int t, input int s);
      ins_valid[t] = 1'b1;
      ins_seq[t*SEQ_W +: SEQ_W] = SEQ_W'(s);
      step();
   endtask

   task automatic exsq(input int t, input int s, input bit incl, input bit mp);
      ex_valid[t] = 1'b1;
      ex_seq[t*SEQ_W +: SEQ_W] = SEQ_W'(s);
      ex_incl[t] = incl;
      ex_mispred[t] = mp;
      ex_pc[t*PC_W +: PC_W] = PC_W'(16'h2000 + s);
      step();
   endtask

   task automatic release_sq(input int t);
      rob_sq_done[t] = 1'b1;
      step();
      check("R6 done returns to Running", st(t), 3'd1);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      saved_pc = {16'h1100, 16'h1000};
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      step();
      // R8 reset state
      for (int t = 0; t < NT; t++) begin
         check("R8 state idle", st(t), 3'd0);
         check("R8 no squash", bc_squash[t], 1'b0);
         check("R8 not busy", bc_busy[t], 1'b0);
         check("R8 no conflict", conflict[t], 1'b0);
         check("R8 done seq zero", dseq(t), 0);
      end

      // R7 insert moves Idle to Running
      insert(0, 20);
      check("R7 idle to running", st(0), 3'd1);
      check("R9 other thread untouched", st(1), 3'd0);

      // R3/R4 sweep around the youngest boundary
      for (int s = 17; s <= 23; s++) begin
         for (int incl = 0; incl < 2; incl++) begin
            bit acc;
            acc = (s <= 20);
            insert(0, 20);
            exsq(0, s, incl[0], s[0]);
            check("R3 accept iff seq<=youngest", bc_squash[0], acc);
            if (acc) begin
               check("R4 squash point", dseq(0), s - incl);
               check("R4 mispred copied", bc_mispred[0], s[0]);
               check("R4 redirect from execute", rdir(0), 16'h2000 + s);
               check("R6 enters squashing", st(0), 3'd2);
               step();
               check("R6 busy reasserted", bc_busy[0], 1'b1);
               check("R9 squash pulse single cycle", bc_squash[0], 1'b0);
               release_sq(0);
            end else begin
               check("R3 rejected keeps Running", st(0), 3'd1);
            end
         end
      end

      // R4 youngest becomes the squash point
      insert(0, 20);
      exsq(0, 20, 1'b1, 1'b0);
      check("R4 include gives seq-1", dseq(0), 19);
      release_sq(0);
      exsq(0, 20, 1'b0, 1'b0);
      check("R4 youngest now 19 rejects 20", bc_squash[0], 1'b0);
      exsq(0, 19, 1'b0, 1'b0);
      check("R4 youngest 19 accepts 19", bc_squash[0], 1'b1);
      release_sq(0);

      // R7 insert ignored while squashing
      insert(0, 40);
      exsq(0, 30, 1'b0, 1'b0);
      check("R3 accepted 30", bc_squash[0], 1'b1);
      insert(0, 90);
      check("R7 still squashing", st(0), 3'd2);
      release_sq(0);
      exsq(0, 60, 1'b0, 1'b0);
      check("R7 ignored insert leaves youngest 30", bc_squash[0], 1'b0);
      exsq(0, 30, 1'b0, 1'b0);
      check("R7 youngest 30 accepts 30", bc_squash[0], 1'b1);
      release_sq(0);

      // R1/R5 countdown sweep, both threads, both trap kinds
      for (int t = 0; t < NT; t++) begin
         for (int kind = 0; kind < 2; kind++) begin
            for (int L = 0; L < 16; L++) begin
               insert(t, 50);
               rob_empty[t] = L[0];
               rob_head_seq[t*SEQ_W +: SEQ_W] = SEQ_W'(L + 10);
               trap_lat = LAT_W'(L);
               if (kind == 0) trap_req[t] = 1'b1; else ftrap_req[t] = 1'b1;
               step();
               check("R1 trap state code", st(t), kind == 0 ? 3'd3 : 3'd4);
               for (int k = 1; k <= L + 2; k++) begin
                  step();
                  if (k < L + 2) check("R1 no early squash", bc_squash[t], 1'b0);
               end
               check("R1 squash after L+2", bc_squash[t], 1'b1);
               check("R5 squash point", dseq(t), L[0] ? 0 : L + 9);
               check("R5 redirect saved pc", rdir(t), t == 0 ? 16'h1000 : 16'h1100);
               check("R5 mispred cleared", bc_mispred[t], 1'b0);
               check("R9 other thread quiet", bc_squash[1-t], 1'b0);
               release_sq(t);
               // R5 youngest reset to 0: seq 1 now rejected
               exsq(t, 1, 1'b0, 1'b0);
               check("R5 youngest reset to zero", bc_squash[t], 1'b0);
            end
         end
      end
      rob_empty = '1;

      // R3 trap-pending blocks execute squash
      insert(0, 50);
      trap_lat = 4'd6;
      trap_req[0] = 1'b1;
      step();
      exsq(0, 10, 1'b0, 1'b0);
      check("R3 blocked while trap pending", bc_squash[0], 1'b0);
      check("R3 state stays trap", st(0), 3'd3);
      for (int k = 2; k <= 8; k++) step();
      check("R1 blocked trap still squashes at L+2", bc_squash[0], 1'b1);
      release_sq(0);

      // R3 fetch-trap does not block
      insert(0, 50);
      ftrap_req[0] = 1'b1;
      step();
      exsq(0, 10, 1'b0, 1'b1);
      check("R3 fetch-trap allows execute squash", bc_squash[0], 1'b1);
      check("R4 point during fetch-trap", dseq(0), 10);
      release_sq(0);
      for (int k = 3; k <= 8; k++) step();
      check("R1 fetch-trap squash after L+2", bc_squash[0], 1'b1);
      check("R5 redirect after fetch-trap", rdir(0), 16'h1000);
      release_sq(0);

      // R2 trap and context squash collide
      insert(0, 50);
      trap_lat = 4'd0;
      trap_req[0] = 1'b1;
      step();
      ctx_req[0] = 1'b1;
      step();
      check("R2 conflict flagged", conflict[0], 1'b1);
      check("R2 no squash yet", bc_squash[0], 1'b0);
      step();
      check("R2 trap squash handled", bc_squash[0], 1'b1);
      check("R2 conflict cleared", conflict[0], 1'b0);
      step();
      check("R2 context squash next cycle", bc_squash[0], 1'b1);
      check("R2 state squashing", st(0), 3'd2);
      step();
      check("R9 squash pulses end", bc_squash[0], 1'b0);
      release_sq(0);

      // R5 context squash alone on thread 1
      insert(1, 5);
      ctx_req[1] = 1'b1;
      step();
      step();
      check("R5 context squash", bc_squash[1], 1'b1);
      check("R5 empty buffer point zero", dseq(1), 0);
      check("R9 thread 0 quiet", bc_squash[0], 1'b0);
      release_sq(1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule